// File: doc/BRIEF.md
# Bus Clock-Stop Tracker with Core and Graphics Clock Enables

This block sits on the device side of a PCI bus that uses the CLKRUN# clock-stop handshake. It samples the shared open-drain CLKRUN# line, which the central clock resource controls. It follows the bus through three phases: clock running, stop requested and clock stopped. The block then turns that phase into clock enables for the device core and for the graphics-port (AGP) clock domain.

Local gating is off until a global enable bit is set. With the bit clear, the core enable stays high and the block never interferes with a stop request. With the bit set, two things happen. The core enable drops while the bus clock is stopped. When local work is pending, the block pulls CLKRUN# low for a fixed number of clocks, either to refuse a stop that is being requested or to ask for a stopped clock to restart. A separate kill bit holds the AGP domain's enable low whatever the bus phase is.

Top module: `clkrun_gate`

## Requirements
- R1: While reset is asserted and after it is released, the block is in the running phase: `clkrun_pd_o` is 0, `core_ce_o` is 1, and `agp_ce_o` is 1 when `agp_off_i` is 0.
- R2: In the running phase, the line read high (`clkrun_n_i`=1) at a clock edge starts a stop request. If the line then stays high with no local activity, the phase becomes stopped at the STOP_WAIT+1-th edge after the first high sample. With `gate_en_i`=1, `core_ce_o` stays 1 after STOP_WAIT edges and reads 0 after STOP_WAIT+1 edges.
- R3: The line read low during a stop request abandons it and returns to running. A later stop again needs the full STOP_WAIT+1 edges.
- R4: In the stopped phase the line keeps being sampled. A low sample (driven by any agent) returns to running, and `core_ce_o` is 1 after that edge.
- R5: With `gate_en_i`=0, `clkrun_pd_o` is never 1 and `core_ce_o` is always 1, even with `busy_i`=1 and the bus stopped.
- R6: With `gate_en_i`=1 and `busy_i`=1 during a stop request while the line is high, `clkrun_pd_o` rises at the next edge, stays 1 for exactly HOLD clocks (default 2) and then returns to 0. The resulting low line sends the phase back to running, so `core_ce_o` never drops.
- R7: With `gate_en_i`=1 and `busy_i`=1 in the stopped phase, `clkrun_pd_o` is driven for HOLD clocks, and `core_ce_o` returns to 1 one edge after the pull-down starts.
- R8: With `agp_off_i`=1, `agp_ce_o` is 0 in every phase. With `agp_off_i`=0, `agp_ce_o` equals `core_ce_o`.
- R9: `core_ce_o` is 0 only in the stopped phase with `gate_en_i`=1. Clearing `gate_en_i` while stopped raises `core_ce_o` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clkrun_n_i | input | 1 | Sampled level of the open-drain CLKRUN# line (low = asserted) |
| busy_i | input | 1 | Local activity pending; the clock is wanted |
| gate_en_i | input | 1 | Global local-gating enable (reset value 0 in the register that drives it) |
| agp_off_i | input | 1 | Permanent kill for the AGP clock-domain enable |
| clkrun_pd_o | output | 1 | Pull-down enable for CLKRUN#; 1 drives the line low |
| core_ce_o | output | 1 | Core clock enable |
| agp_ce_o | output | 1 | AGP clock-domain enable |

## Verification
The bench models the wired line as the AND of the central resource's drive and the block's own pull-down, so every refusal loops back through the line. The tracker is exercised with an unbroken high run that reaches the stopped phase, which separates a correct stop delay from an off-by-one. It is also exercised with a high run cut short by a low pulse, which shows whether the wait count restarts. Busy pulses are applied both during a request and during the stopped phase; these show whether the pull-down length is right and whether the block wakes from its own drive. Each of these patterns is repeated with gating disabled and with the AGP kill set, which separates the effect of the configuration bits from the effect of the bus phase.

// File: rtl/clkrun_gate.sv
module clkrun_gate #(
  parameter int STOP_WAIT = 4,
  parameter int HOLD      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clkrun_n_i,
  input  logic busy_i,
  input  logic gate_en_i,
  input  logic agp_off_i,
  output logic clkrun_pd_o,
  output logic core_ce_o,
  output logic agp_ce_o
);

  localparam int WW = $clog2(STOP_WAIT + 1);
  localparam int HW = $clog2(HOLD + 1);

  typedef enum logic [1:0] {ST_RUN, ST_REQ, ST_OFF} st_t;

  st_t            st_q, st_d;
  logic [WW-1:0]  wait_q;
  logic [HW-1:0]  hold_q;
  logic           holding;
  logic           kick;
  logic           wait_done;

  assign holding   = (hold_q != '0);
  assign kick      = gate_en_i && busy_i && clkrun_n_i && !holding && (st_q != ST_RUN);
  assign wait_done = (wait_q == WW'(STOP_WAIT - 1));

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RUN:  if (clkrun_n_i) st_d = ST_REQ;
      ST_REQ: begin
        if (!clkrun_n_i)                        st_d = ST_RUN;
        else if (!kick && !holding && wait_done) st_d = ST_OFF;
      end
      ST_OFF:  if (!clkrun_n_i) st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      wait_q <= '0;
      hold_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_REQ && clkrun_n_i && !kick && !holding)
        wait_q <= wait_q + 1'b1;
      else
        wait_q <= '0;
      if (kick)
        hold_q <= HW'(HOLD);
      else if (holding)
        hold_q <= hold_q - 1'b1;
    end
  end

  assign clkrun_pd_o = holding;
  assign core_ce_o   = !(st_q == ST_OFF && gate_en_i);
  assign agp_ce_o    = core_ce_o && !agp_off_i;

endmodule

// File: rtl/clkrun_gate_chk.sv
module clkrun_gate_chk #(
  parameter int STOP_WAIT = 4,
  parameter int HOLD      = 2
) (
  input logic clk,
  input logic rst_n,
  input logic clkrun_n_i,
  input logic busy_i,
  input logic gate_en_i,
  input logic agp_off_i,
  input logic clkrun_pd_o,
  input logic core_ce_o,
  input logic agp_ce_o
);

  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= '0;
    else if (clkrun_pd_o) run_q <= (run_q == 8'hFF) ? run_q : run_q + 8'd1;
    else                  run_q <= '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!clkrun_pd_o && core_ce_o);
    end
  end

  p_wake_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_ce_o && !clkrun_n_i) |=> core_ce_o);

  p_no_drive_ungated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en_i |-> !clkrun_pd_o);

  p_pd_max_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 8'(HOLD));

  p_pd_full_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clkrun_pd_o) |-> run_q == 8'(HOLD));

  p_agp_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    agp_off_i |-> !agp_ce_o);

  p_ce_ungated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en_i |-> core_ce_o);

endmodule

bind clkrun_gate clkrun_gate_chk #(.STOP_WAIT(STOP_WAIT), .HOLD(HOLD)) u_chk (.*);

// File: tb/test_clkrun_gate.sv
`timescale 1ns/1ps
module test_clkrun_gate;
  localparam int STOP_WAIT = 4;
  localparam int HOLD      = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic host_low = 1;
  logic busy = 0, gate_en = 0, agp_off = 0;
  logic line_n;
  logic pd, core_ce, agp_ce;
  int   checks = 0, errors = 0;

  always #10 clk = ~clk;

  assign line_n = !(host_low || pd);

  clkrun_gate #(.STOP_WAIT(STOP_WAIT), .HOLD(HOLD)) i_clkrun_gate (
    .clk(clk), .rst_n(rst_n), .clkrun_n_i(line_n), .busy_i(busy),
    .gate_en_i(gate_en), .agp_off_i(agp_off),
    .clkrun_pd_o(pd), .core_ce_o(core_ce), .agp_ce_o(agp_ce)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic go_stopped;
    host_low = 0;
    step(STOP_WAIT + 1);
  endtask

  task automatic wake;
    host_low = 1;
    step(1);
  endtask

  task automatic t_reset;
    step(2);
    chk("R1", "pd in reset", pd, 1'b0);
    chk("R1", "core_ce in reset", core_ce, 1'b1);
    chk("R1", "agp_ce in reset", agp_ce, 1'b1);
    rst_n = 1;
    step(3);
    chk("R1", "pd after reset", pd, 1'b0);
    chk("R1", "core_ce after reset", core_ce, 1'b1);
  endtask

  task automatic t_stop_wake;
    gate_en = 1;
    host_low = 0;
    step(STOP_WAIT);
    chk("R2", "core_ce before stop delay", core_ce, 1'b1);
    step(1);
    chk("R2", "core_ce at stop", core_ce, 1'b0);
    step(2);
    chk("R2", "core_ce holds while stopped", core_ce, 1'b0);
    wake();
    chk("R4", "core_ce after wake", core_ce, 1'b1);
  endtask

  task automatic t_abort;
    host_low = 0;
    step(2);
    host_low = 1;
    step(1);
    host_low = 0;
    step(STOP_WAIT);
    chk("R3", "no early stop after abort", core_ce, 1'b1);
    step(1);
    chk("R3", "stop after full wait", core_ce, 1'b0);
    wake();
    chk("R4", "wake after abort test", core_ce, 1'b1);
  endtask

  task automatic t_refuse_req;
    host_low = 0;
    busy = 1;
    step(1);
    chk("R6", "pd before refusal", pd, 1'b0);
    step(1);
    chk("R6", "pd first refusal clock", pd, 1'b1);
    chk("R6", "core_ce during refusal", core_ce, 1'b1);
    step(1);
    chk("R6", "pd second refusal clock", pd, 1'b1);
    host_low = 1;
    busy = 0;
    step(1);
    chk("R6", "pd released", pd, 1'b0);
    chk("R6", "core_ce after refusal", core_ce, 1'b1);
  endtask

  task automatic t_refuse_off;
    go_stopped();
    chk("R7", "stopped before busy", core_ce, 1'b0);
    busy = 1;
    step(1);
    chk("R7", "pd starts in stopped", pd, 1'b1);
    chk("R7", "core_ce still off", core_ce, 1'b0);
    step(1);
    chk("R7", "pd second clock", pd, 1'b1);
    chk("R7", "core_ce restored", core_ce, 1'b1);
    host_low = 1;
    busy = 0;
    step(1);
    chk("R7", "pd released", pd, 1'b0);
  endtask

  task automatic t_ungated;
    logic pd_seen = 0, ce_low_seen = 0;
    gate_en = 0;
    busy = 1;
    host_low = 0;
    for (int i = 0; i < STOP_WAIT + 4; i++) begin
      step(1);
      if (pd) pd_seen = 1;
      if (!core_ce) ce_low_seen = 1;
    end
    chk("R5", "pd never driven ungated", pd_seen, 1'b0);
    chk("R5", "core_ce never low ungated", ce_low_seen, 1'b0);
    busy = 0;
    wake();
    gate_en = 1;
    step(1);
    chk("R5", "core_ce after regating in running", core_ce, 1'b1);
  endtask

  task automatic t_gate_clear;
    go_stopped();
    chk("R9", "stopped with gating", core_ce, 1'b0);
    gate_en = 0;
    #1;
    chk("R9", "core_ce on gate clear", core_ce, 1'b1);
    gate_en = 1;
    #1;
    chk("R9", "core_ce on gate set again", core_ce, 1'b0);
    wake();
    chk("R9", "core_ce running", core_ce, 1'b1);
  endtask

  task automatic t_agp;
    agp_off = 1;
    step(1);
    chk("R8", "agp_ce off while running", agp_ce, 1'b0);
    go_stopped();
    chk("R8", "agp_ce off while stopped", agp_ce, 1'b0);
    agp_off = 0;
    step(1);
    chk("R8", "agp_ce follows core_ce stopped", agp_ce, core_ce);
    chk("R8", "agp_ce low when stopped", agp_ce, 1'b0);
    wake();
    chk("R8", "agp_ce high when running", agp_ce, 1'b1);
  endtask

  initial begin
    t_reset();
    t_stop_wake();
    t_abort();
    t_refuse_req();
    t_refuse_off();
    t_ungated();
    t_gate_clear();
    t_agp();
    step(2);
    report();
  end

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

endmodule